// File: doc/BRIEF.md
# Increment/Decrement Execution Unit

This unit carries out the one-byte step instructions of a small 8-bit accumulator processor. An opcode is presented with a start pulse. The unit decodes it into one of three forms and runs it. The first form steps one of seven byte registers. The second form steps one of four 16-bit register pairs. The third form steps a memory byte addressed by the HL pair, using a read, a modify and a write back. The unit keeps its own register file and flag nibble, and its own program counter. The surrounding core preloads these through a small write port and observes them through a read view.

The byte and memory forms update the zero, subtract and half-carry flags. The pair forms change no flag. No form touches the carry flag. An opcode outside the map completes at once, raises an illegal indication and changes no state. Memory is a synchronous single port: read data appears in the cycle after a read request.

Top module: `incdec_unit`

## Requirements
- R1: Byte-register forms follow the opcode map. 0x04/0x0C/0x14/0x1C/0x24/0x2C/0x3C increment B/C/D/E/H/L/A, and 0x05/0x0D/0x15/0x1D/0x25/0x2D/0x3D decrement the same registers. Results wrap modulo 256. In `gpr_o`, bits [8i+7:8i] hold slot i, where slots 0..5 are B,C,D,E,H,L, slot 7 is A, and slot 6 always reads 0.
- R2: 0x34 increments and 0x35 decrements the memory byte at HL. A read request (`mem_req_o`=1, `mem_we_o`=0) is issued, and two cycles later a write (`mem_we_o`=1) of the new value goes to the same address. `done_o` pulses three cycles later than for a register form.
- R3: 0x03/0x13/0x23/0x33 increment BC/DE/HL/SP, and 0x0B/0x1B/0x2B/0x3B decrement them. Results wrap modulo 65536. All flags stay unchanged.
- R4: For the byte and memory forms, N (`flags_o[2]`) is 0 after an increment and 1 after a decrement.
- R5: H (`flags_o[1]`) is 1 when an increment carries out of the low nibble (low nibble was 0xF), or when a decrement borrows into it (low nibble was 0x0). Otherwise H is 0.
- R6: Z (`flags_o[3]`) is 1 exactly when the 8-bit result is zero.
- R7: Every legal opcode advances `pc_o` by exactly 1.
- R8: C (`flags_o[0]`) is never changed by any step form.
- R9: An unmapped opcode pulses `illegal_o` and `done_o` in the cycle after acceptance. Registers, flags, PC and memory are left unchanged.
- R10: A byte-register, pair or illegal opcode has `done_o` high in the cycle directly after the accepting clock edge, for one cycle.
- R11: `start_i` is ignored while `busy_o` is high (during a memory form).
- R12: Reset gives PC=0x0100, SP=0xFFFE, and all byte registers and flags 0. When idle and not starting, `wr_en_i` loads a target chosen by `wr_sel_i`: 0 BC, 1 DE, 2 HL, 3 SP, 4 A from `wr_data_i[15:8]` with flags from `wr_data_i[3:0]`, 5 PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Execute `opcode_i` (taken when idle) |
| opcode_i | input | 8 | Instruction byte |
| wr_en_i | input | 1 | Register preload strobe |
| wr_sel_i | input | 3 | Preload target select |
| wr_data_i | input | 16 | Preload value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory address (HL) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read request |
| gpr_o | output | 64 | Byte register view |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |
| flags_o | output | 4 | {Z,N,H,C} |
| busy_o | output | 1 | Memory form in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completion was an unmapped opcode |

## Verification
A wrong decode or ALU result is visible in the register view, flags or PC in the same cycle that `done_o` pulses. For a register form that is one cycle after the start. A fault in the memory sequencer shows up as a missing read request, a write two cycles later to a different address, or a done pulse at the wrong cycle. A stray write to the carry bit, or to any state during an illegal or refused start, is visible on the next cycle. The random mix preloads random pair and accumulator values, so nibble boundaries and wraps are reached from many starting points.

// File: rtl/incdec_pkg.sv
package incdec_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PAIR_W = 2 * BYTE_W;
    localparam int unsigned NSLOT  = 8;
    localparam logic [2:0]  MEM_SLOT = 3'd6;

    typedef enum logic [1:0] {OP_NONE, OP_R8, OP_R16, OP_MEM} op_kind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CAP, ST_WR} seq_e;

    typedef struct packed {
        logic       legal;
        op_kind_e   kind;
        logic       down;
        logic [2:0] r8_sel;
        logic [1:0] pair_sel;
    } op_dec_t;
endpackage

// File: rtl/incdec_decode.sv
module incdec_decode
    import incdec_pkg::*;
(
    input  logic [7:0] opcode_i,
    output op_dec_t    dec_o
);
    always_comb begin
        dec_o      = '0;
        dec_o.kind = OP_NONE;
        if (opcode_i[7:6] == 2'b00) begin
            case (opcode_i[2:0])
                3'b100, 3'b101: begin
                    dec_o.legal  = 1'b1;
                    dec_o.down   = opcode_i[0];
                    dec_o.r8_sel = opcode_i[5:3];
                    dec_o.kind   = (opcode_i[5:3] == MEM_SLOT) ? OP_MEM : OP_R8;
                end
                3'b011: begin
                    dec_o.legal    = 1'b1;
                    dec_o.down     = opcode_i[3];
                    dec_o.pair_sel = opcode_i[5:4];
                    dec_o.kind     = OP_R16;
                end
                default: dec_o.kind = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/incdec_alu8.sv
module incdec_alu8
    import incdec_pkg::*;
(
    input  logic [BYTE_W-1:0] val_i,
    input  logic              down_i,
    output logic [BYTE_W-1:0] res_o,
    output logic              z_o,
    output logic              n_o,
    output logic              h_o
);
    always_comb begin
        res_o = down_i ? (val_i - 1'b1) : (val_i + 1'b1);
        z_o   = (res_o == '0);
        n_o   = down_i;
        h_o   = down_i ? (val_i[3:0] == 4'h0) : (val_i[3:0] == 4'hF);
    end
endmodule

// File: rtl/incdec_unit.sv
module incdec_unit
    import incdec_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter logic [15:0] RST_PC = 16'h0100,
    parameter logic [15:0] RST_SP = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [15:0]       wr_data_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [15:0]       mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [63:0]       gpr_o,
    output logic [15:0]       sp_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [3:0]        flags_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o
);
    localparam int unsigned FZ = 3, FN = 2, FH = 1, FC = 0;

    typedef struct packed {
        seq_e                          seq;
        logic [NSLOT-1:0][BYTE_W-1:0]  gpr;
        logic [PAIR_W-1:0]             sp;
        logic [PC_W-1:0]               pc;
        logic [3:0]                    flags;
        logic [BYTE_W-1:0]             tmp;
        logic                          down;
        logic                          done;
        logic                          illegal;
    } state_t;

    state_t  st_d, st_q;
    op_dec_t dec;
    logic    accept;
    logic [BYTE_W-1:0] alu_in, alu_res;
    logic    alu_down, alu_z, alu_n, alu_h;

    incdec_decode u_decode (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    assign alu_in   = (st_q.seq == ST_CAP) ? mem_rdata_i : st_q.gpr[dec.r8_sel];
    assign alu_down = (st_q.seq == ST_CAP) ? st_q.down   : dec.down;

    incdec_alu8 u_alu (
        .val_i  (alu_in),
        .down_i (alu_down),
        .res_o  (alu_res),
        .z_o    (alu_z),
        .n_o    (alu_n),
        .h_o    (alu_h)
    );

    function automatic logic [PAIR_W-1:0] pair_rd(state_t s, logic [1:0] p);
        case (p)
            2'd0:    return {s.gpr[0], s.gpr[1]};
            2'd1:    return {s.gpr[2], s.gpr[3]};
            2'd2:    return {s.gpr[4], s.gpr[5]};
            default: return s.sp;
        endcase
    endfunction

    function automatic state_t pair_wr(state_t s, logic [1:0] p, logic [PAIR_W-1:0] v);
        state_t r;
        r = s;
        case (p)
            2'd0:    {r.gpr[0], r.gpr[1]} = v;
            2'd1:    {r.gpr[2], r.gpr[3]} = v;
            2'd2:    {r.gpr[4], r.gpr[5]} = v;
            default: r.sp = v;
        endcase
        return r;
    endfunction

    assign accept = start_i && (st_q.seq == ST_IDLE);

    always_comb begin
        logic [PAIR_W-1:0] pv;
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        pv           = pair_rd(st_q, dec.pair_sel);
        case (st_q.seq)
            ST_IDLE: begin
                if (accept) begin
                    if (!dec.legal) begin
                        st_d.done    = 1'b1;
                        st_d.illegal = 1'b1;
                    end else begin
                        case (dec.kind)
                            OP_R8: begin
                                st_d.gpr[dec.r8_sel] = alu_res;
                                st_d.flags[FZ] = alu_z;
                                st_d.flags[FN] = alu_n;
                                st_d.flags[FH] = alu_h;
                                st_d.pc   = st_q.pc + 1'b1;
                                st_d.done = 1'b1;
                            end
                            OP_R16: begin
                                st_d = pair_wr(st_d, dec.pair_sel,
                                               dec.down ? (pv - 1'b1) : (pv + 1'b1));
                                st_d.pc   = st_q.pc + 1'b1;
                                st_d.done = 1'b1;
                            end
                            OP_MEM: begin
                                st_d.seq  = ST_RD;
                                st_d.down = dec.down;
                            end
                            default: st_d.seq = ST_IDLE;
                        endcase
                    end
                end else if (wr_en_i) begin
                    case (wr_sel_i)
                        3'd0, 3'd1, 3'd2, 3'd3:
                            st_d = pair_wr(st_q, wr_sel_i[1:0], wr_data_i);
                        3'd4: begin
                            st_d.gpr[7] = wr_data_i[15:8];
                            st_d.flags  = wr_data_i[3:0];
                        end
                        3'd5:    st_d.pc = wr_data_i[PC_W-1:0];
                        default: st_d.seq = ST_IDLE;
                    endcase
                end
            end
            ST_RD:  st_d.seq = ST_CAP;
            ST_CAP: begin
                st_d.tmp       = alu_res;
                st_d.flags[FZ] = alu_z;
                st_d.flags[FN] = alu_n;
                st_d.flags[FH] = alu_h;
                st_d.pc        = st_q.pc + 1'b1;
                st_d.seq       = ST_WR;
            end
            default: begin
                st_d.seq  = ST_IDLE;
                st_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.seq     <= ST_IDLE;
            st_q.sp      <= RST_SP;
            st_q.pc      <= RST_PC[PC_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_o   = (st_q.seq == ST_RD) || (st_q.seq == ST_WR);
    assign mem_we_o    = (st_q.seq == ST_WR);
    assign mem_addr_o  = {st_q.gpr[4], st_q.gpr[5]};
    assign mem_wdata_o = st_q.tmp;
    assign gpr_o       = st_q.gpr;
    assign sp_o        = st_q.sp;
    assign pc_o        = st_q.pc;
    assign flags_o     = st_q.flags;
    assign busy_o      = (st_q.seq != ST_IDLE);
    assign done_o      = st_q.done;
    assign illegal_o   = st_q.illegal;

    // R7: a register-form opcode accepted by the decoder moves the PC by one
    p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.legal && dec.kind != OP_MEM) |=> (pc_o == $past(pc_o) + 1'b1));

    // R8: carry only changes through the preload port
    p_carry_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (flags_o[FC] == $past(flags_o[FC])));

    // R2: every write is preceded, two cycles earlier, by a read of the same address
    p_mem_rmw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |->
            ($past(mem_req_o, 2) && !$past(mem_we_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));

    // R9: an illegal completion leaves architectural state untouched
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (pc_o == $past(pc_o) && gpr_o == $past(gpr_o)
                       && sp_o == $past(sp_o) && flags_o == $past(flags_o)));

    // R11: a start during a memory form changes no register
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (gpr_o == $past(gpr_o) && sp_o == $past(sp_o)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/incdec_unit_tb.sv
`timescale 1ns/1ps
module incdec_unit_tb;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic [63:0] gpr_o;
    logic [15:0] sp_o, pc_o;
    logic [3:0]  flags_o;
    logic        busy_o, done_o, illegal_o;

    incdec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .gpr_o(gpr_o), .sp_o(sp_o), .pc_o(pc_o), .flags_o(flags_o),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    logic [7:0] mem [0:65535];
    always_ff @(posedge clk) begin
        if (mem_req_o && mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o];
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  m_gpr [0:7];
    logic [15:0] m_sp, m_pc;
    logic [3:0]  m_f;

    logic [7:0] inc8_op [0:7] = '{8'h04, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h2C, 8'h34, 8'h3C};
    logic [7:0] pair_op [0:7] = '{8'h03, 8'h13, 8'h23, 8'h33, 8'h0B, 8'h1B, 8'h2B, 8'h3B};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_view();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = (i == 6) ? 8'h00 : m_gpr[i];
        return v;
    endfunction

    function automatic logic [15:0] m_hl();
        return {m_gpr[4], m_gpr[5]};
    endfunction

    task automatic cmp_state(input string req);
        chk(gpr_o == model_view(), req, gpr_o, model_view());
        chk({sp_o, pc_o, flags_o} == {m_sp, m_pc, m_f}, req, {sp_o, pc_o, flags_o}, {m_sp, m_pc, m_f});
    endtask

    // expected 8-bit step: returns {result, Z, N, H}
    function automatic logic [10:0] step8(input logic [7:0] v, input bit down);
        logic [7:0] r;
        r = down ? v - 8'd1 : v + 8'd1;
        return {r, r == 8'd0, down, down ? (v[3:0] == 4'h0) : (v[3:0] == 4'hF)};
    endfunction

    task automatic load(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        case (sel)
            3'd0: {m_gpr[0], m_gpr[1]} = d;
            3'd1: {m_gpr[2], m_gpr[3]} = d;
            3'd2: {m_gpr[4], m_gpr[5]} = d;
            3'd3: m_sp = d;
            3'd4: begin m_gpr[7] = d[15:8]; m_f = d[3:0]; end
            3'd5: m_pc = d;
            default: ;
        endcase
    endtask

    task automatic exec(input logic [7:0] op);
        int kind, idx, cnt, exp_lat;
        bit down;
        logic [10:0] s;
        logic [15:0] pv, a;
        logic [7:0] mexp;
        kind = 0; idx = 0; down = 0;
        for (int i = 0; i < 8; i++) begin
            if (op == inc8_op[i])        begin kind = (i == 6) ? 3 : 1; idx = i; down = 0; end
            if (op == inc8_op[i] + 8'd1) begin kind = (i == 6) ? 3 : 1; idx = i; down = 1; end
            if (op == pair_op[i])        begin kind = 2; idx = i % 4; down = (i >= 4); end
        end
        a = m_hl();
        mexp = mem[a];
        @(negedge clk);
        start_i = 1'b1; opcode_i = op;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!done_o && cnt < 10) begin @(negedge clk); cnt++; end
        exp_lat = (kind == 3) ? 4 : 1;
        case (kind)
            0: begin
                chk(illegal_o === 1'b1, "R9 illegal flag", illegal_o, 1);
            end
            1: begin
                s = step8(m_gpr[idx], down);
                m_gpr[idx] = s[10:3];
                m_f = {s[2:0], m_f[0]};
                m_pc++;
            end
            2: begin
                case (idx)
                    0: pv = {m_gpr[0], m_gpr[1]};
                    1: pv = {m_gpr[2], m_gpr[3]};
                    2: pv = {m_gpr[4], m_gpr[5]};
                    default: pv = m_sp;
                endcase
                pv = down ? pv - 16'd1 : pv + 16'd1;
                case (idx)
                    0: {m_gpr[0], m_gpr[1]} = pv;
                    1: {m_gpr[2], m_gpr[3]} = pv;
                    2: {m_gpr[4], m_gpr[5]} = pv;
                    default: m_sp = pv;
                endcase
                m_pc++;
            end
            default: begin
                s = step8(mexp, down);
                m_f = {s[2:0], m_f[0]};
                m_pc++;
                @(negedge clk);
                chk(mem[a] == s[10:3], "R2 memory byte", mem[a], s[10:3]);
            end
        endcase
        chk(cnt == exp_lat, (kind == 3) ? "R2 latency" : "R10 latency", cnt, exp_lat);
        if (kind != 0) chk(illegal_o === 1'b0, "R9 legal not flagged", illegal_o, 0);
        case (kind)
            0: cmp_state("R9 state kept");
            1: cmp_state("R1 R4 R5 R6 R7 R8 byte form");
            2: cmp_state("R3 R7 R8 pair form");
            default: cmp_state("R2 R4 R5 R6 R7 R8 memory form");
        endcase
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] legal [0:21];
        void'($urandom(32'd20240613));
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 37 + 5);
        for (int i = 0; i < 8; i++) m_gpr[i] = 8'h00;
        m_sp = 16'hFFFE; m_pc = 16'h0100; m_f = 4'h0;
        for (int i = 0; i < 8; i++) begin
            legal[2*i] = inc8_op[i]; legal[2*i+1] = inc8_op[i] + 8'd1;
        end
        for (int i = 0; i < 6; i++) legal[16+i] = pair_op[i];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_state("R12 reset state");
        chk({busy_o, done_o, illegal_o} == 3'b000, "R12 reset outputs", {busy_o, done_o, illegal_o}, 0);

        // directed corners
        load(3'd4, 16'h0F01); exec(8'h3C);        // 0x0F -> 0x10, H=1, C kept
        chk(flags_o == 4'b0011, "R5 inc half carry", flags_o, 4'b0011);
        load(3'd4, 16'h1000); exec(8'h3D);        // 0x10 -> 0x0F, H=1, N=1
        chk(flags_o == 4'b0110, "R4 R5 dec half borrow", flags_o, 4'b0110);
        load(3'd4, 16'h0100); exec(8'h3D);        // 1 -> 0, Z=1
        chk(flags_o[3] == 1'b1, "R6 zero on dec", flags_o, 4'b1100);
        load(3'd4, 16'h0000); exec(8'h3C);        // 0 -> 1, Z=0
        chk(flags_o[3] == 1'b0, "R6 no zero on inc", flags_o, 4'b0000);
        load(3'd0, 16'hFF00); exec(8'h04);        // B 0xFF -> 0x00, Z=1 H=1
        chk(gpr_o[7:0] == 8'h00 && flags_o[3] && flags_o[1], "R1 wrap", gpr_o[7:0], 0);
        load(3'd4, 16'h0005); load(3'd0, 16'h0FFF); exec(8'h03);
        chk(flags_o == 4'h5, "R3 flags kept", flags_o, 4'h5);
        load(3'd3, 16'h0000); exec(8'h3B);
        chk(sp_o == 16'hFFFF, "R3 pair wrap", sp_o, 16'hFFFF);
        load(3'd2, 16'h4000); mem[16'h4000] = 8'h0F; exec(8'h34);
        load(3'd2, 16'h4001); mem[16'h4001] = 8'h10; exec(8'h35);
        exec(8'h00); exec(8'h76); exec(8'hFF);

        // R11: start held during a memory form
        load(3'd2, 16'h4100); mem[16'h4100] = 8'h20;
        @(negedge clk); start_i = 1'b1; opcode_i = 8'h34;
        @(negedge clk); opcode_i = 8'h04;
        @(negedge clk); @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        m_f = {3'b000, m_f[0]}; m_pc++;
        chk(done_o == 1'b1, "R11 memory form completes", done_o, 1);
        cmp_state("R11 start ignored when busy");
        @(negedge clk);
        chk(mem[16'h4100] == 8'h21, "R11 memory result", mem[16'h4100], 8'h21);

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            r = $urandom % 16;
            if (r < 3) load(3'($urandom % 5), 16'($urandom));
            else if (r == 3) exec(8'($urandom));
            else exec(legal[$urandom % 22]);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule